// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

This block is a watchdog that runs through four timing stages in a fixed order. Each stage has its own timeout, counted in clock cycles, and its own action when it runs out. The action can be nothing, an interrupt, a CPU reset, a system reset, or a full reset that also reaches the always-on domain. Software keeps the watchdog quiet by feeding it. A feed sends the sequence back to stage 0 and restarts its counter from zero. If software stops feeding, the consequences escalate stage by stage.

All configuration goes through a simple register write port. A 32-bit key guards the port: until the key is written, every other write is dropped. The CPU reset line and the system reset line are pulse-stretched. Each has its own 3-bit length code, and the length is counted in cycles of a reference clock. The always-on reset line reuses the system length. A read port returns the protect state, the enable state, the configuration and the current stage.

Top module: `wdog_escalator`

## Requirements
- R1: After reset the block is write-protected (address 0 reads bit0 = 1) and disabled (address 1 reads 0). The stage status at address 9 reads 0, all outputs are low, and each stage timeout at addresses 4..7 reads 16'hFFFF.
- R2: Writing 32'h5AFE_C0DE to address 0 clears protection. Writing any other value to address 0 sets it. The protect state reads back as bit0 of address 0.
- R3: While protected, every write to any address other than 0 is dropped. This covers enable (address 1, bit0), feed (address 2), lengths (address 3), timeouts (addresses 4..7) and actions (address 8).
- R4: Once enabled, stage s expires max(T,1) cycles after it is entered, where T is its timeout. The first stage is entered at the clock edge that samples the enabling write. Expiry moves the block to stage s+1 and restarts its counter at 0.
- R5: The action of stage i sits in bits [3i+2:3i] of address 8, coded 0 = none, 1 = interrupt, 2 = CPU reset, 3 = system reset, 4 = full reset. Codes 5 to 7 behave as none. A stage with no action changes no output when it expires.
- R6: The interrupt output rises at the edge of an expiry whose action is interrupt. It stays high until a feed or a disable.
- R7: The CPU reset action pulses the CPU reset line, with its length taken from address 3 bits [6:4]. The system reset action pulses the system line, with its length taken from address 3 bits [2:0]. The full reset action pulses both the system line and the always-on line with the system length. Each pulse starts at the edge of the expiry.
- R8: Length code c gives a pulse of U(c) x CLKS_PER_100NS cycles. U is 1, 2, 3, 4, 5, 8, 16 or 32 for c = 0..7.
- R9: After stage 3 expires, the block stays in stage 3 and performs no further action until it is fed or disabled. Address 9 then reads bit2 = 1 with stage bits [1:0] = 3.
- R10: An accepted feed write returns the block to stage 0 with its counter at 0, at the edge that samples the write. If a feed and an expiry fall in the same cycle, the feed wins and the expiry's action is not taken.
- R11: Writing 0 to the enable bit returns the block to stage 0, one cycle after the write edge. The same edge clears the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block and reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Watchdog interrupt, level |
| cpu_rst_o | output | 1 | Stretched CPU reset pulse |
| sys_rst_o | output | 1 | Stretched system reset pulse |
| aon_rst_o | output | 1 | Stretched always-on domain reset pulse |

## Verification
The hardest case to reach from the ports is a feed that lands in the exact cycle in which a stage expires. The feed's write has to be sampled on the same edge that would advance the stage. The stimulus counts edges from the enabling write and issues the feed write so that it is sampled on edge C+T. The scoreboard then expects no pulse at that edge, and a pulse one full timeout later. Every reset pulse is checked against a queued rise cycle and width, so stray or missing pulses after the stage 3 hold also show up as mismatches.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int NSTAGE = 4;
  localparam int STG_W  = $clog2(NSTAGE);
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int NLINE  = 3;

  // reset line indices
  localparam int LN_CPU = 0;
  localparam int LN_SYS = 1;
  localparam int LN_AON = 2;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h5AFE_C0DE;

  // register addresses
  localparam logic [ADDR_W-1:0] A_PROT = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd1;
  localparam logic [ADDR_W-1:0] A_FEED = 4'd2;
  localparam logic [ADDR_W-1:0] A_LEN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_TMO0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_ACT  = 4'd8;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd9;

  typedef enum logic [2:0] {
    ACT_NONE = 3'd0,
    ACT_IRQ  = 3'd1,
    ACT_CPU  = 3'd2,
    ACT_SYS  = 3'd3,
    ACT_FULL = 3'd4
  } act_e;

  // pulse length in 100 ns units for a 3-bit code
  function automatic int unsigned pulse_units(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 5;
      3'd5: return 8;
      3'd6: return 16;
      default: return 32;
    endcase
  endfunction

  // which reset lines an action code drives
  function automatic logic [NLINE-1:0] act_lines(input logic [2:0] code);
    logic [NLINE-1:0] v;
    v = '0;
    case (code)
      ACT_CPU:  v[LN_CPU] = 1'b1;
      ACT_SYS:  v[LN_SYS] = 1'b1;
      ACT_FULL: begin v[LN_SYS] = 1'b1; v[LN_AON] = 1'b1; end
      default:  v = '0;
    endcase
    return v;
  endfunction

  // stage expiry test: counter has run its full timeout (zero treated as one)
  function automatic logic tmo_reached(input logic [31:0] cnt, input logic [31:0] tmo);
    return ({1'b0, cnt} + 33'd1) >= {1'b0, tmo};
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              en_o,
  output logic              feed_o,
  output logic [2:0]        len_cpu_o,
  output logic [2:0]        len_sys_o,
  output logic [TMO_W-1:0]  tmo_o [NSTAGE],
  output logic [2:0]        act_o [NSTAGE],
  input  logic [STG_W-1:0]  stage_i,
  input  logic              done_i
);

  logic prot_q;
  logic wr_ok;
  logic prot_wr;

  assign prot_wr = wr_en && (wr_addr == A_PROT);
  assign wr_ok   = wr_en && !prot_q && (wr_addr != A_PROT);
  assign feed_o  = wr_ok && (wr_addr == A_FEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b1;
    end else if (prot_wr) begin
      prot_q <= (wr_data != UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o      <= 1'b0;
      len_cpu_o <= 3'd0;
      len_sys_o <= 3'd0;
    end else if (wr_ok) begin
      if (wr_addr == A_CTRL) en_o <= wr_data[0];
      if (wr_addr == A_LEN) begin
        len_sys_o <= wr_data[2:0];
        len_cpu_o <= wr_data[6:4];
      end
    end
  end

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage_cfg
    localparam logic [ADDR_W-1:0] MY_TMO = A_TMO0 + ADDR_W'(s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tmo_o[s] <= '1;
        act_o[s] <= ACT_NONE;
      end else if (wr_ok) begin
        if (wr_addr == MY_TMO) tmo_o[s] <= wr_data[TMO_W-1:0];
        if (wr_addr == A_ACT)  act_o[s] <= wr_data[3*s +: 3];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_PROT: rd_data[0] = prot_q;
      A_CTRL: rd_data[0] = en_o;
      A_LEN:  begin rd_data[2:0] = len_sys_o; rd_data[6:4] = len_cpu_o; end
      A_ACT:  for (int s = 0; s < NSTAGE; s++) rd_data[3*s +: 3] = act_o[s];
      A_STAT: begin rd_data[STG_W-1:0] = stage_i; rd_data[STG_W] = done_i; end
      default: begin
        for (int s = 0; s < NSTAGE; s++)
          if (rd_addr == A_TMO0 + ADDR_W'(s)) rd_data[TMO_W-1:0] = tmo_o[s];
      end
    endcase
  end

  // R3: a locked write leaves configuration untouched
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && wr_en && wr_addr != A_PROT) |=>
      ($stable(en_o) && $stable(len_sys_o) && $stable(len_cpu_o) && $stable(tmo_o[0])));

  // R2: the key always unlocks, any other value always locks
  a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr && wr_data == UNLOCK_KEY) |=> !prot_q);
  a_r2_other_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr && wr_data != UNLOCK_KEY) |=> prot_q);

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
  import wdog_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             feed_i,
  input  logic [TMO_W-1:0] tmo_i [NSTAGE],
  input  logic [2:0]       act_i [NSTAGE],
  output logic [STG_W-1:0] stage_o,
  output logic             done_o,
  output logic             irq_o,
  output logic             irq_set_o,
  output logic [NLINE-1:0] fire_o
);

  localparam logic [STG_W-1:0] LAST = STG_W'(NSTAGE - 1);

  logic [TMO_W-1:0] cnt_q;
  logic             expire;   // current stage has run out
  logic             take;     // expiry that is acted upon
  logic [2:0]       cur_act;

  assign cur_act   = act_i[stage_o];
  assign expire    = en_i && !done_o && tmo_reached(32'(cnt_q), 32'(tmo_i[stage_o]));
  assign take      = expire && !feed_i;
  assign fire_o    = take ? act_lines(cur_act) : '0;
  assign irq_set_o = take && (cur_act == ACT_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_o <= '0;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else if (!en_i || feed_i) begin
      stage_o <= '0;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else if (take) begin
      cnt_q <= '0;
      if (stage_o == LAST) done_o  <= 1'b1;
      else                 stage_o <= stage_o + 1'b1;
    end else if (!done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               irq_o <= 1'b0;
    else if (!en_i || feed_i) irq_o <= 1'b0;
    else if (irq_set_o)       irq_o <= 1'b1;
  end

  // R10: feed restarts at stage 0 with a cleared counter
  a_r10_feed_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && feed_i) |=> (stage_o == '0 && cnt_q == '0 && !done_o));

  // R9: final stage holds once expired
  a_r9_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && done_o && !feed_i) |=> (done_o && stage_o == LAST));

  // R4: an expiry before the last stage steps exactly one stage
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (take && stage_o != LAST) |=> (stage_o == $past(stage_o) + 1'b1 && cnt_q == '0));

  // R11: disabled means back at stage 0
  a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (stage_o == '0 && !done_o));

  // R5: an action of none or a spare code fires nothing
  a_r5_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && (cur_act == ACT_NONE || cur_act > ACT_FULL)) |-> (fire_o == '0 && !irq_set_o));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
#(
  parameter int CLKS_PER_100NS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire_i,
  input  logic [2:0] code_i,
  output logic       pulse_o
);

  localparam int MAX_LEN = 32 * CLKS_PER_100NS;
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] left_q;
  logic [CW-1:0] load_len;

  assign load_len = CW'(pulse_units(code_i) * CLKS_PER_100NS);
  assign pulse_o  = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left_q <= '0;
    else if (fire_i)        left_q <= load_len;
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  // R8: a fired pulse is high on the next cycle
  a_r8_fire_starts: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> pulse_o);

  // R8: without a new fire the pulse never grows
  a_r8_only_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> (left_q <= $past(left_q)));

endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
  import wdog_pkg::*;
#(
  parameter int TMO_W          = 16,
  parameter int CLKS_PER_100NS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq_o,
  output logic        cpu_rst_o,
  output logic        sys_rst_o,
  output logic        aon_rst_o
);

  logic             en;
  logic             feed;
  logic [2:0]       len_cpu;
  logic [2:0]       len_sys;
  logic [TMO_W-1:0] tmo [NSTAGE];
  logic [2:0]       act [NSTAGE];
  logic [STG_W-1:0] stage;
  logic             done;
  logic             irq_set;
  logic [NLINE-1:0] fire;
  logic [NLINE-1:0] pulse;
  logic [2:0]       line_code [NLINE];

  wdog_regs #(.TMO_W(TMO_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .en_o(en), .feed_o(feed), .len_cpu_o(len_cpu), .len_sys_o(len_sys),
    .tmo_o(tmo), .act_o(act), .stage_i(stage), .done_i(done)
  );

  wdog_seq #(.TMO_W(TMO_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en), .feed_i(feed),
    .tmo_i(tmo), .act_i(act),
    .stage_o(stage), .done_o(done), .irq_o(irq_o),
    .irq_set_o(irq_set), .fire_o(fire)
  );

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    assign line_code[l] = (l == LN_CPU) ? len_cpu : len_sys;
    wdog_pulse #(.CLKS_PER_100NS(CLKS_PER_100NS)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire_i(fire[l]),
      .code_i(line_code[l]), .pulse_o(pulse[l])
    );
  end

  assign cpu_rst_o = pulse[LN_CPU];
  assign sys_rst_o = pulse[LN_SYS];
  assign aon_rst_o = pulse[LN_AON];

  // R6: the interrupt only rises on an interrupt-action expiry
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(irq_set));

  // R7: the always-on line is never pulsed without the system line
  a_r7_aon_with_sys: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aon_rst_o) |-> sys_rst_o);

endmodule

// File: tb/test_wdog_escalator.sv
module test_wdog_escalator;

  localparam int CLK_PERIOD = 10;
  localparam int CPU100 = 2;

  typedef struct { int rise; int width; } pulse_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_o, cpu_rst_o, sys_rst_o, aon_rst_o;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  pulse_t exp_q [3][$];
  logic [2:0] prev_l = '0;
  logic [2:0] now_l;
  int st [3];
  int wd [3];

  wdog_escalator #(.TMO_W(16), .CLKS_PER_100NS(CPU100)) i_wdog_escalator (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o),
    .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o), .aon_rst_o(aon_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_len(input int code);
    return (code < 5 ? code + 1 : (1 << (code - 2))) * CPU100;
  endfunction

  function automatic logic [31:0] acts(input int a0, a1, a2, a3);
    return {20'd0, 3'(a3), 3'(a2), 3'(a1), 3'(a0)};
  endfunction

  // driver side of the scoreboard
  task automatic expect_pulse(input int line, input int rise, input int width);
    pulse_t p;
    p.rise = rise; p.width = width;
    exp_q[line].push_back(p);
  endtask

  // monitor side: measure each completed pulse and compare
  always @(negedge clk) begin
    now_l = {aon_rst_o, sys_rst_o, cpu_rst_o};
    for (int l = 0; l < 3; l++) begin
      if (now_l[l] && !prev_l[l]) begin
        st[l] = cyc; wd[l] = 1;
      end else if (now_l[l]) begin
        wd[l]++;
      end else if (prev_l[l]) begin
        if (exp_q[l].size() == 0) begin
          chk(1'b0, $sformatf("R5/R7 unexpected pulse line%0d", l), st[l], -1);
        end else begin
          pulse_t e;
          e = exp_q[l].pop_front();
          chk(st[l] == e.rise, $sformatf("R7 rise line%0d", l), st[l], e.rise);
          chk(wd[l] == e.width, $sformatf("R8 width line%0d", l), wd[l], e.width);
        end
      end
    end
    prev_l = now_l;
  end

  // called at a negedge; returns at the negedge after the sampling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d, output int edge_n);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    edge_n = cyc + 1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wrq(input logic [3:0] a, input logic [31:0] d);
    int e;
    wr(a, d, e);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic setup(input int t0, t1, t2, t3, input logic [31:0] act, input int lc, ls);
    wrq(4'd1, 32'd0);
    wrq(4'd4, 32'(t0)); wrq(4'd5, 32'(t1)); wrq(4'd6, 32'(t2)); wrq(4'd7, 32'(t3));
    wrq(4'd8, act);
    wrq(4'd3, 32'((lc << 4) | ls));
  endtask

  task automatic drain(input string req);
    repeat (80) @(negedge clk);
    for (int l = 0; l < 3; l++) begin
      chk(exp_q[l].size() == 0, $sformatf("%s missing pulse line%0d", req, l), exp_q[l].size(), 0);
      exp_q[l].delete();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c, f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(4'd0, d); chk(d == 1, "R1 protect after reset", d, 1);
    rd(4'd1, d); chk(d == 0, "R1 enable after reset", d, 0);
    rd(4'd9, d); chk(d == 0, "R1 stage after reset", d, 0);
    rd(4'd4, d); chk(d == 32'hFFFF, "R1 timeout reset", d, 32'hFFFF);
    chk({irq_o, cpu_rst_o, sys_rst_o, aon_rst_o} == 0, "R1 outputs low", 32'({irq_o, cpu_rst_o, sys_rst_o, aon_rst_o}), 0);

    // R3: locked writes dropped
    wrq(4'd1, 32'd1); wrq(4'd4, 32'd7); wrq(4'd3, 32'h77);
    rd(4'd1, d); chk(d == 0, "R3 enable locked", d, 0);
    rd(4'd4, d); chk(d == 32'hFFFF, "R3 timeout locked", d, 32'hFFFF);
    rd(4'd3, d); chk(d == 0, "R3 length locked", d, 0);

    // R2: key handling
    wrq(4'd0, 32'h5AFE_C0DE); rd(4'd0, d); chk(d == 0, "R2 key unlocks", d, 0);
    wrq(4'd0, 32'h5AFE_C0DF); rd(4'd0, d); chk(d == 1, "R2 wrong key locks", d, 1);
    wrq(4'd0, 32'h5AFE_C0DE); rd(4'd0, d); chk(d == 0, "R2 key unlocks again", d, 0);

    // R8: every length code on both lines
    for (int code = 0; code < 8; code++) begin
      setup(5, 3, 50, 50, acts(2, 3, 0, 0), code, 7 - code);
      wr(4'd1, 32'd1, c);
      expect_pulse(0, c + 5, exp_len(code));
      expect_pulse(1, c + 8, exp_len(7 - code));
      wait_until(c + 80);
      wrq(4'd1, 32'd0);
      drain("R8");
    end

    // R4/R6/R7/R9: escalation through all four stages
    setup(4, 6, 8, 10, acts(1, 2, 3, 4), 1, 2);
    wr(4'd1, 32'd1, c);
    expect_pulse(0, c + 10, 4);
    expect_pulse(1, c + 18, 6);
    expect_pulse(1, c + 28, 6);
    expect_pulse(2, c + 28, 6);
    wait_until(c + 3);  chk(irq_o == 0, "R4 irq before stage0 expiry", irq_o, 0);
    wait_until(c + 4);  chk(irq_o == 1, "R6 irq at stage0 expiry", irq_o, 1);
    rd(4'd9, d);        chk(d == 1, "R4 stage 1 reached", d, 1);
    wait_until(c + 120);
    rd(4'd9, d);        chk(d == 7, "R9 hold in last stage", d, 7);
    chk(irq_o == 1, "R6 irq held", irq_o, 1);
    wr(4'd2, 32'd0, f);
    chk(irq_o == 0, "R10 feed clears irq", irq_o, 1'b0);
    rd(4'd9, d);        chk(d == 0, "R10 feed back to stage 0", d, 0);
    wrq(4'd1, 32'd0);
    drain("R9");

    // R10: feed in the middle of stage 0
    setup(10, 3, 200, 200, acts(0, 2, 0, 0), 0, 0);
    wr(4'd1, 32'd1, c);
    wait_until(c + 6);
    wr(4'd2, 32'd0, f);
    expect_pulse(0, f + 13, 2);
    wait_until(f + 9);  rd(4'd9, d); chk(d == 0, "R10 still stage 0 after feed", d, 0);
    wait_until(f + 11); rd(4'd9, d); chk(d == 1, "R10 stage 1 after restart", d, 1);
    wait_until(f + 30);
    wrq(4'd1, 32'd0);
    drain("R10");

    // R3: feed dropped while locked
    setup(10, 3, 200, 200, acts(0, 2, 0, 0), 0, 0);
    wr(4'd1, 32'd1, c);
    wrq(4'd0, 32'd0);
    wait_until(c + 4);
    wrq(4'd2, 32'd0);
    expect_pulse(0, c + 13, 2);
    wait_until(c + 30);
    wrq(4'd0, 32'h5AFE_C0DE);
    wrq(4'd1, 32'd0);
    drain("R3");

    // R10: feed on the expiry edge wins
    setup(5, 200, 200, 200, acts(2, 0, 0, 0), 3, 0);
    wr(4'd1, 32'd1, c);
    wait_until(c + 4);
    wr(4'd2, 32'd0, f);
    chk(f == c + 5, "R10 feed aligned to expiry", f, c + 5);
    expect_pulse(0, f + 5, exp_len(3));
    wait_until(f + 7);
    wrq(4'd1, 32'd0);
    drain("R10 collision");

    // R5: spare action code behaves as none
    setup(3, 3, 200, 200, acts(6, 2, 0, 0), 0, 0);
    wr(4'd1, 32'd1, c);
    expect_pulse(0, c + 6, 2);
    wait_until(c + 5); chk(irq_o == 0, "R5 spare code no irq", irq_o, 0);
    wait_until(c + 20);
    wrq(4'd1, 32'd0);
    drain("R5");

    // R11: disable clears irq and stage
    setup(4, 200, 200, 200, acts(1, 0, 0, 0), 0, 0);
    wr(4'd1, 32'd1, c);
    wait_until(c + 6); chk(irq_o == 1, "R6 irq set before disable", irq_o, 1);
    wr(4'd1, 32'd0, f);
    @(negedge clk);
    chk(irq_o == 0, "R11 disable clears irq", irq_o, 0);
    rd(4'd9, d); chk(d == 0, "R11 disable resets stage", d, 0);
    drain("R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule